// File: doc/BRIEF.md
# Programmable Interval Interrupt Clock

This peripheral turns one of four free-running reference tick streams into interrupt requests for the processor. The reference ticks are independent of processor timing. Each tick stream is a single-cycle enable already synchronised to `clk_i`. Software picks the rate once with a data-out write. It then arms the clock by setting Busy. The next tick of the selected rate moves the clock from Busy to Done. Done raises the interrupt line unless the interrupt mask bit is set.

Software re-arms after every interrupt. Ticks that arrive while the clock is not armed are dropped, so no backlog builds up. Because arming can happen at any point in a period, the first interrupt after arming can come at any phase within that period. Later interrupts follow the reference rate as long as software re-arms in time.

The crystal-derived rates need time to settle after power-on. For a parameterised number of cycles after power-on reset, the block suppresses the crystal-derived ticks. Line-frequency ticks are usable at once. An I/O reset puts the rate back to line frequency and clears the handshake. It does not restart the settling interval.

Top module: `rtc_interval_clock`

## Requirements
- R1: A write (`wr_i` high) loads `rate_i` into the rate register. The code 2'b00 selects `tick_line_i`, 2'b01 selects `tick_10_i`, 2'b10 selects `tick_100_i` and 2'b11 selects `tick_1k_i`. The new rate governs ticks from the next rising edge on.
- R2: While Busy is set and no command is present, a tick of the selected rate clears Busy and sets Done at that edge.
- R3: `irq_o` equals Done AND NOT `int_dis_i`, combinationally.
- R4: `start_i` sets Busy and clears Done. `pulse_i` sets Busy and leaves Done unchanged.
- R5: `clear_i` clears both Busy and Done. The priority is: I/O reset, then clear, then start, then pulse, then tick.
- R6: Ticks while Busy is clear are ignored and do not accumulate. A tick that lands before arming never produces Done after arming.
- R7: On the first SETTLE_CYCLES rising edges after `rst_ni` is released, ticks of the three crystal rates are ignored. Line-frequency ticks are honoured from the first edge.
- R8: `io_reset_i` sets the rate to line frequency and clears Busy and Done. It does not restart the settling interval.
- R9: After power-on reset, Busy, Done and `irq_o` are low and the rate is line frequency.
- R10: The rate persists across any number of start, pulse and clear commands until the next write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| io_reset_i | input | 1 | Synchronous I/O reset |
| wr_i | input | 1 | Data-out write strobe |
| rate_i | input | 2 | Rate code written by `wr_i` |
| start_i | input | 1 | Set Busy, clear Done |
| clear_i | input | 1 | Clear Busy and Done |
| pulse_i | input | 1 | Set Busy, keep Done |
| int_dis_i | input | 1 | Interrupt mask |
| tick_line_i | input | 1 | Line-frequency tick enable |
| tick_10_i | input | 1 | 10 Hz tick enable |
| tick_100_i | input | 1 | 100 Hz tick enable |
| tick_1k_i | input | 1 | 1000 Hz tick enable |
| busy_o | output | 1 | Busy flag |
| done_o | output | 1 | Done flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Busy and Done change at the rising edge that samples a command or a selected tick, so both are due one edge after the stimulus is applied. A rate write affects tick selection from the next edge. `irq_o` follows Done and the mask in the same cycle, with no register between them.

The bench drives inputs on the falling edge and applies its reference model at each rising edge. It compares all three outputs 1 ns after that edge, which is exactly when the registered results are due. The settling window is counted in edges since reset release, with a short parameter value. This places crystal-rate ticks on both sides of its last suppressed edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    RATE_LINE = 2'b00,
    RATE_10   = 2'b01,
    RATE_100  = 2'b10,
    RATE_1K   = 2'b11
  } rate_e;
endpackage

// File: rtl/rtc_settle.sv
module rtc_settle #(
  parameter int unsigned SETTLE_CYCLES = 1000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic settled_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);

  logic [CW-1:0] cnt_q;

  // only power-on reset restarts the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign settled_o = (cnt_q == LIMIT);
endmodule

// File: rtl/rtc_rate_sel.sv
module rtc_rate_sel
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       io_reset_i,
  input  logic       wr_i,
  input  logic [1:0] rate_i,
  input  logic       settled_i,
  input  logic       tick_line_i,
  input  logic       tick_10_i,
  input  logic       tick_100_i,
  input  logic       tick_1k_i,
  output rate_e      rate_o,
  output logic       sel_tick_o
);
  rate_e rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rate_q <= RATE_LINE;
    else if (io_reset_i) rate_q <= RATE_LINE;
    else if (wr_i)       rate_q <= rate_e'(rate_i);
  end

  always_comb begin
    unique case (rate_q)
      RATE_LINE: sel_tick_o = tick_line_i;
      RATE_10:   sel_tick_o = settled_i & tick_10_i;
      RATE_100:  sel_tick_o = settled_i & tick_100_i;
      default:   sel_tick_o = settled_i & tick_1k_i;
    endcase
  end

  assign rate_o = rate_q;
endmodule

// File: rtl/rtc_handshake.sv
module rtc_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_reset_i,
  input  logic start_i,
  input  logic clear_i,
  input  logic pulse_i,
  input  logic tick_i,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (io_reset_i || clear_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (pulse_i) begin
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/rtc_interval_clock.sv
module rtc_interval_clock
  import rtc_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 1000000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       io_reset_i,
  input  logic       wr_i,
  input  logic [1:0] rate_i,
  input  logic       start_i,
  input  logic       clear_i,
  input  logic       pulse_i,
  input  logic       int_dis_i,
  input  logic       tick_line_i,
  input  logic       tick_10_i,
  input  logic       tick_100_i,
  input  logic       tick_1k_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       irq_o
);
  logic  settled;
  logic  sel_tick;
  rate_e rate_q;

  rtc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .settled_o (settled)
  );

  rtc_rate_sel u_rate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_reset_i  (io_reset_i),
    .wr_i        (wr_i),
    .rate_i      (rate_i),
    .settled_i   (settled),
    .tick_line_i (tick_line_i),
    .tick_10_i   (tick_10_i),
    .tick_100_i  (tick_100_i),
    .tick_1k_i   (tick_1k_i),
    .rate_o      (rate_q),
    .sel_tick_o  (sel_tick)
  );

  rtc_handshake u_hs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .io_reset_i (io_reset_i),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .pulse_i    (pulse_i),
    .tick_i     (sel_tick),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign irq_o = done_o & ~int_dis_i;
endmodule

// File: rtl/rtc_interval_clock_chk.sv
module rtc_interval_clock_chk
  import rtc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       io_reset_i,
  input logic       wr_i,
  input logic [1:0] rate_i,
  input logic       start_i,
  input logic       clear_i,
  input logic       pulse_i,
  input logic       int_dis_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       irq_o,
  input logic       settled_i,
  input logic       sel_tick_i,
  input rate_e      rate_q_i
);
  logic no_cmd;
  assign no_cmd = !io_reset_i && !clear_i && !start_i && !pulse_i;

  a_r1_rate_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !io_reset_i |=> rate_q_i == rate_e'($past(rate_i)));

  a_r2_tick_to_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && sel_tick_i && no_cmd |=> done_o && !busy_o);

  a_r3_mask_blocks_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_dis_i |-> !irq_o);

  a_r4_start_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !clear_i && !io_reset_i |=> busy_o && !done_o);

  a_r5_clear_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !busy_o && !done_o);

  a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && no_cmd |=> !busy_o && $stable(done_o));

  a_r7_settle_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !settled_i && rate_q_i != RATE_LINE |-> !sel_tick_i);

  a_r8_io_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_reset_i |=> rate_q_i == RATE_LINE && !busy_o && !done_o);
endmodule

bind rtc_interval_clock rtc_interval_clock_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .io_reset_i (io_reset_i),
  .wr_i       (wr_i),
  .rate_i     (rate_i),
  .start_i    (start_i),
  .clear_i    (clear_i),
  .pulse_i    (pulse_i),
  .int_dis_i  (int_dis_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .irq_o      (irq_o),
  .settled_i  (settled),
  .sel_tick_i (sel_tick),
  .rate_q_i   (rate_q)
);

// File: tb/tb_rtc_interval_clock.sv
`timescale 1ns/1ps
module tb_rtc_interval_clock;
  localparam int unsigned SETTLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_reset = 0, wr = 0, start = 0, clear = 0, pulse = 0, int_dis = 0;
  logic [1:0] rate = 2'b00;
  logic t_line = 0, t_10 = 0, t_100 = 0, t_1k = 0;
  logic busy, done, irq;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [1:0] m_rate;
  logic m_busy, m_done;
  int   m_edges;

  always #2.5 clk = ~clk;

  rtc_interval_clock #(.SETTLE_CYCLES(SETTLE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .io_reset_i(io_reset), .wr_i(wr), .rate_i(rate),
    .start_i(start), .clear_i(clear), .pulse_i(pulse), .int_dis_i(int_dis),
    .tick_line_i(t_line), .tick_10_i(t_10), .tick_100_i(t_100), .tick_1k_i(t_1k),
    .busy_o(busy), .done_o(done), .irq_o(irq)
  );

  function automatic logic model_tick(logic [1:0] r, logic settled,
                                     logic l, logic a, logic b, logic c);
    case (r)
      2'b00:   return l;
      2'b01:   return settled & a;
      2'b10:   return settled & b;
      default: return settled & c;
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(string req);
    check(req, "busy", busy, m_busy);
    check(req, "done", done, m_done);
    check("R3", "irq", irq, m_done & ~int_dis);
  endtask

  task automatic clr_in();
    io_reset = 0; wr = 0; start = 0; clear = 0; pulse = 0;
    t_line = 0; t_10 = 0; t_100 = 0; t_1k = 0;
  endtask

  // inputs already applied after a falling edge; advance one rising edge
  task automatic step(string req);
    logic tk;
    @(posedge clk);
    tk = model_tick(m_rate, m_edges >= int'(SETTLE), t_line, t_10, t_100, t_1k);
    if (io_reset || clear) begin m_busy = 0; m_done = 0; end
    else if (start)        begin m_busy = 1; m_done = 0; end
    else if (pulse)        m_busy = 1;
    else if (m_busy && tk) begin m_busy = 0; m_done = 1; end
    if (io_reset) m_rate = 2'b00;
    else if (wr)  m_rate = rate;
    m_edges++;
    #1;
    check_outs(req);
    @(negedge clk);
    clr_in();
  endtask

  initial begin
    #(5ns * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_rate = 2'b00; m_busy = 0; m_done = 0; m_edges = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check_outs("R9");
    rst_n = 1'b1;

    // R7/R9: line rate usable immediately after reset
    start = 1; step("R4");
    t_line = 1; step("R7");
    check("R7", "line done", done, 1'b1);
    // R1: select 1 kHz; R7 crystal ticks suppressed while settling
    wr = 1; rate = 2'b11; step("R1");
    start = 1; step("R4");
    t_1k = 1; step("R7");
    check("R7", "1k suppressed busy", busy, 1'b1);
    t_line = 1; step("R1");
    check("R1", "line ignored at 1k", busy, 1'b1);
    while (m_edges < int'(SETTLE) - 1) step("R7");
    t_1k = 1; step("R7"); // last suppressed edge
    check("R7", "last settle edge", done, 1'b0);
    t_1k = 1; step("R7"); // first honoured edge
    check("R7", "first honoured", done, 1'b1);

    // R6: idle ticks ignored, no accumulation
    clear = 1; step("R5");
    repeat (5) begin t_1k = 1; step("R6"); end
    start = 1; step("R6");
    step("R6");
    check("R6", "no stored tick", done, 1'b0);
    // R5 priority: clear beats start
    clear = 1; start = 1; step("R5");
    // R4: pulse keeps done
    start = 1; step("R4");
    t_1k = 1; step("R2");
    pulse = 1; step("R4");
    check("R4", "pulse keeps done", done, 1'b1);
    // R5 priority: start beats same-cycle tick
    start = 1; t_1k = 1; step("R5");
    // R3: mask
    t_1k = 1; int_dis = 1; step("R3");
    int_dis = 0; #1 check_outs("R3");

    // R10: rate survives commands
    wr = 1; rate = 2'b01; step("R1");
    repeat (3) begin clear = 1; step("R10"); start = 1; step("R10"); end
    t_100 = 1; t_1k = 1; step("R10");
    t_10 = 1; step("R10");
    check("R10", "10Hz kept", done, 1'b1);

    // R8: io reset returns to line, keeps settled
    start = 1; step("R8");
    io_reset = 1; step("R8");
    start = 1; step("R8");
    t_10 = 1; step("R8");
    check("R8", "10Hz after io reset", busy, 1'b1);
    t_line = 1; step("R8");
    wr = 1; rate = 2'b10; step("R8");
    start = 1; step("R8");
    t_100 = 1; step("R8");
    check("R8", "settle not restarted", done, 1'b1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      io_reset = (r < 2);
      clear    = (r >= 2 && r < 6);
      start    = (r >= 6 && r < 16);
      pulse    = (r >= 16 && r < 20);
      wr       = ($urandom_range(0, 19) == 0);
      rate     = 2'($urandom_range(0, 3));
      int_dis  = ($urandom_range(0, 3) == 0);
      t_line   = ($urandom_range(0, 5) == 0);
      t_10     = ($urandom_range(0, 5) == 0);
      t_100    = ($urandom_range(0, 5) == 0);
      t_1k     = ($urandom_range(0, 5) == 0);
      step("R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule